// File: doc/BRIEF.md
# Dual-Mode Serial Character Transmitter

This block turns bytes written over a parallel port into a single serial bit stream. A CPU writes one character at a time into a holding register. Whenever the output shifter has no bits left to send, the waiting byte is copied into it at the next bit-rate tick. The CPU can therefore stage the next byte while the current one is still going out. A one-cycle enable, `bitTick`, sets the bit rate. Each tick places exactly one new bit on the line.

In asynchronous mode every character is framed: a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. In synchronous mode there is no framing. A programmable sync character opens every burst. Whenever the CPU fails to supply the next byte in time, the block fills the line with the sync character and raises `txEmpty`. Data resumes as soon as a byte is written.

A new character can start only while the active-low clear-to-send input is asserted. The configuration inputs (mode, character length, parity, stop-bit count, sync character) are sampled only while the transmitter is idle.

Top module: `stx_top`

## Requirements
- R1: After reset, `txd` is high, `txRdy` is high and `txEmpty` is high.
- R2: A write (`wrEn` high) is accepted only while `txRdy` is high. `txRdy` reads low from the clock after the accepted write. A write made while `txRdy` is low is ignored, so the byte that was already held is the one transmitted.
- R3: At a character boundary (a tick with no bits left in the shifter), a held byte is copied into the shifter. The first bit of that character appears on `txd` one clock after the tick, in the same cycle that `txRdy` returns high.
- R4: A new character starts only at a boundary tick during which `ctsN` is low. While `ctsN` is high the line stays high and a held byte stays held.
- R5: An asynchronous frame is sent in this order: start bit 0, the data bits LSB first, the parity bit if enabled, then one stop bit of 1 (two if `cfgTwoStop` is 1). Each bit lasts from one tick to the next, and `txd` changes one clock after each tick.
- R6: `cfgLen` selects 5 + `cfgLen` data bits, so 0 gives 5 bits and 3 gives 8 bits. Data bits above the selected length are never sent.
- R7: With `cfgParEn` = 1, the parity bit follows the data bits. With `cfgParOdd` = 0 it makes the number of ones in data plus parity even. With `cfgParOdd` = 1 it makes that number odd.
- R8: If a byte is held when a character ends, the next character's first bit goes out at the very next tick, with no idle bit in between.
- R9: In synchronous mode (`cfgSync` = 1) there are no start or stop bits. The first character after idle is always the sync character, even if a data byte is already held. Held data follows it.
- R10: In synchronous mode, a boundary with no byte held sends the sync character as fill and raises `txEmpty`. `txEmpty` falls one clock after a write is accepted, and the written byte follows the fill character.
- R11: The configuration is captured only in cycles when no bits remain to be placed and no synchronous burst is running. A change made during a character takes effect from the next character.
- R12: When no character is being sent, `txd` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | CPU write strobe |
| wrData | input | DATA_W | Byte to transmit |
| cfgSync | input | 1 | 1 = synchronous mode, 0 = asynchronous |
| cfgLen | input | LEN_W | Character length code: MIN_BITS + code data bits |
| cfgParEn | input | 1 | Parity bit enable |
| cfgParOdd | input | 1 | 1 = odd parity, 0 = even |
| cfgTwoStop | input | 1 | Two stop bits in asynchronous mode |
| cfgSyncChar | input | DATA_W | Sync/fill character |
| ctsN | input | 1 | Clear to send, active low |
| bitTick | input | 1 | One-cycle bit-rate enable |
| txd | output | 1 | Serial output line |
| txRdy | output | 1 | Holding register free for a write |
| txEmpty | output | 1 | Shifter ran out with nothing held |

## Verification
Every result has a fixed latency:
- `txd` changes one clock after the tick that places the bit.
- `txRdy` and `txEmpty` react one clock after an accepted write.
- At a boundary, `txRdy` rises in the same clock that the first bit appears.
- A configuration value needs one clock while idle before it is captured.

The bench drives every input on the falling edge. It holds a tick for exactly one rising edge and reads `txd` at the falling edge that follows, so every bit is checked in the cycle it becomes valid. Status flags are read at that same falling edge after each write or tick.

// File: rtl/stx_pkg.sv
package stx_pkg;

  // Strobes from control to datapath, valid for one clock.
  typedef struct packed {
    logic capCfg;     // sample configuration inputs
    logic shiftOut;   // put the next frame bit on the line
    logic loadData;   // build a frame from the holding register
    logic loadFill;   // build a frame from the sync character
    logic goIdle;     // drive the line high
    logic markEmpty;  // boundary reached with nothing held
  } txStrobe_t;

endpackage

// File: rtl/stx_dp.sv
module stx_dp
  import stx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int LEN_W    = 2,
  parameter int FRAME_W  = 12,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgSync,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic              cfgTwoStop,
  input  logic [DATA_W-1:0] cfgSyncChar,
  input  txStrobe_t         strb,
  output logic              txd,
  output logic              holdFull,
  output logic              txEmpty,
  output logic              cfgSyncQ,
  output logic [CNT_W-1:0]  frameLen
);

  // Captured configuration
  logic [LEN_W-1:0]  cfgLenQ;
  logic              cfgParEnQ, cfgParOddQ, cfgTwoStopQ;
  logic [DATA_W-1:0] cfgSyncCharQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgSyncQ     <= 1'b0;
      cfgLenQ      <= '1;
      cfgParEnQ    <= 1'b0;
      cfgParOddQ   <= 1'b0;
      cfgTwoStopQ  <= 1'b0;
      cfgSyncCharQ <= '0;
    end else if (strb.capCfg) begin
      cfgSyncQ     <= cfgSync;
      cfgLenQ      <= cfgLen;
      cfgParEnQ    <= cfgParEn;
      cfgParOddQ   <= cfgParOdd;
      cfgTwoStopQ  <= cfgTwoStop;
      cfgSyncCharQ <= cfgSyncChar;
    end
  end

  // Holding register and CPU-side flags
  logic [DATA_W-1:0] holdReg;
  logic              accept;

  assign accept = wrEn && !holdFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      txEmpty  <= 1'b1;
    end else begin
      if (accept) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end else if (strb.loadData) begin
        holdFull <= 1'b0;
      end
      if (accept) txEmpty <= 1'b0;
      else if (strb.markEmpty) txEmpty <= 1'b1;
    end
  end

  // Frame builder: bit 0 is sent first
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   pos, nBits;
  logic [DATA_W-1:0]  src, masked;
  logic               parBit;

  always_comb begin
    frame  = '1;
    pos    = '0;
    masked = '0;
    nBits  = CNT_W'(MIN_BITS) + CNT_W'(cfgLenQ);
    src    = strb.loadData ? holdReg : cfgSyncCharQ;
    if (!cfgSyncQ) begin
      frame[0] = 1'b0;
      pos      = CNT_W'(1);
    end
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < nBits) begin
        frame[pos + CNT_W'(i)] = src[i];
        masked[i]              = src[i];
      end
    end
    pos    = pos + nBits;
    parBit = (^masked) ^ cfgParOddQ;
    if (cfgParEnQ) begin
      frame[pos] = parBit;
      pos        = pos + CNT_W'(1);
    end
    if (!cfgSyncQ) pos = pos + (cfgTwoStopQ ? CNT_W'(2) : CNT_W'(1));
    frameLen = pos;
  end

  // Output shifter
  logic [FRAME_W-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '1;
      txd    <= 1'b1;
    end else if (strb.loadData || strb.loadFill) begin
      txd    <= frame[0];
      shiftQ <= {1'b1, frame[FRAME_W-1:1]};
    end else if (strb.shiftOut) begin
      txd    <= shiftQ[0];
      shiftQ <= {1'b1, shiftQ[FRAME_W-1:1]};
    end else if (strb.goIdle) begin
      txd    <= 1'b1;
    end
  end

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && !strb.loadData) |=> (holdFull && $stable(holdReg)));

  // R12
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.goIdle |=> txd);

  // R10
  empty_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> !holdFull);

endmodule

// File: rtl/stx_ctrl.sv
module stx_ctrl
  import stx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             ctsN,
  input  logic             holdFull,
  input  logic             cfgSyncQ,
  input  logic [CNT_W-1:0] frameLen,
  output txStrobe_t        strb
);

  logic [CNT_W-1:0] bitsLeft;
  logic             syncRun;
  logic             lineFree, atEdge;

  assign lineFree = (bitsLeft == '0);
  assign atEdge   = bitTick && lineFree;

  always_comb begin
    strb          = '0;
    strb.shiftOut = bitTick && !lineFree;
    if (atEdge) begin
      strb.markEmpty = !holdFull;
      if (ctsN) begin
        strb.goIdle = 1'b1;
      end else if (!cfgSyncQ) begin
        if (holdFull) strb.loadData = 1'b1;
        else          strb.goIdle   = 1'b1;
      end else if (syncRun && holdFull) begin
        strb.loadData = 1'b1;
      end else begin
        strb.loadFill = 1'b1;
      end
    end
    strb.capCfg = lineFree && !syncRun && !strb.loadData && !strb.loadFill;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitsLeft <= '0;
      syncRun  <= 1'b0;
    end else begin
      if (strb.loadData || strb.loadFill) begin
        bitsLeft <= frameLen - CNT_W'(1);
        syncRun  <= cfgSyncQ;
      end else if (strb.shiftOut) begin
        bitsLeft <= bitsLeft - CNT_W'(1);
      end
      if (strb.goIdle) syncRun <= 1'b0;
    end
  end

  // R3
  take_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadData |-> holdFull);

  // R4
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadData || strb.loadFill) |-> !ctsN);

  // R8
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadData, strb.loadFill, strb.goIdle, strb.shiftOut}));

  // R9
  sync_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadData && cfgSyncQ) |-> syncRun);

endmodule

// File: rtl/stx_top.sv
module stx_top
  import stx_pkg::*;
#(
  parameter  int DATA_W   = 8,
  parameter  int MIN_BITS = 5,
  localparam int LEN_W    = $clog2(DATA_W - MIN_BITS + 1),
  localparam int FRAME_W  = DATA_W + 4,
  localparam int CNT_W    = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgSync,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              cfgParEn,
  input  logic              cfgParOdd,
  input  logic              cfgTwoStop,
  input  logic [DATA_W-1:0] cfgSyncChar,
  input  logic              ctsN,
  input  logic              bitTick,
  output logic              txd,
  output logic              txRdy,
  output logic              txEmpty
);

  txStrobe_t        strb;
  logic             holdFull, cfgSyncQ;
  logic [CNT_W-1:0] frameLen;

  stx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .ctsN(ctsN),
    .holdFull(holdFull), .cfgSyncQ(cfgSyncQ), .frameLen(frameLen),
    .strb(strb)
  );

  stx_dp #(
    .DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W),
    .FRAME_W(FRAME_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cfgSync(cfgSync), .cfgLen(cfgLen), .cfgParEn(cfgParEn),
    .cfgParOdd(cfgParOdd), .cfgTwoStop(cfgTwoStop),
    .cfgSyncChar(cfgSyncChar), .strb(strb), .txd(txd),
    .holdFull(holdFull), .txEmpty(txEmpty), .cfgSyncQ(cfgSyncQ),
    .frameLen(frameLen)
  );

  assign txRdy = !holdFull;

endmodule

// File: tb/stx_top_tb.sv
`timescale 1ns/1ps
module stx_top_tb;

  logic       clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, bitTick = 1'b0, ctsN = 1'b1;
  logic       cfgSync = 1'b0, cfgParEn = 1'b0, cfgParOdd = 1'b0, cfgTwoStop = 1'b0;
  logic [1:0] cfgLen = 2'd3;
  logic [7:0] wrData = 8'h00, cfgSyncChar = 8'h00;
  logic       txd, txRdy, txEmpty;
  int         total = 0, bad = 0;

  always #4 clk = ~clk;

  stx_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .cfgSync(cfgSync),
    .cfgLen(cfgLen), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .cfgTwoStop(cfgTwoStop), .cfgSyncChar(cfgSyncChar), .ctsN(ctsN),
    .bitTick(bitTick), .txd(txd), .txRdy(txRdy), .txEmpty(txEmpty)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic tickBit(input logic exp, input string tag);
    @(negedge clk) bitTick = 1'b1;
    @(negedge clk) bitTick = 1'b0;
    check(tag, "txd", txd, exp);
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk) begin wrEn = 1'b1; wrData = d; end
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic setCfg(input logic sm, input logic [1:0] len, input logic pe,
                        input logic po, input logic two, input logic [7:0] sc);
    @(negedge clk) begin
      cfgSync = sm; cfgLen = len; cfgParEn = pe;
      cfgParOdd = po; cfgTwoStop = two; cfgSyncChar = sc;
    end
    @(negedge clk);
  endtask

  // Expected line sequence from the requirements (R5, R6, R7, R9)
  task automatic expBits(input logic [7:0] d, input int nb, input logic pe, input logic po,
                         input logic two, input logic sm,
                         output logic [11:0] v, output int n);
    logic p;
    v = '1; n = 0;
    if (!sm) begin v[n] = 1'b0; n++; end
    for (int i = 0; i < nb; i++) begin v[n] = d[i]; n++; end
    if (pe) begin
      p = po;
      for (int i = 0; i < nb; i++) p = p ^ d[i];
      v[n] = p; n++;
    end
    if (!sm) begin
      v[n] = 1'b1; n++;
      if (two) begin v[n] = 1'b1; n++; end
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input int nb, input logic pe, input logic po,
                           input logic two, input logic sm, input string tag,
                           input bit chkRdy, input bit chkEmp, input bit wr2,
                           input logic [7:0] d2);
    logic [11:0] v;
    int n;
    expBits(d, nb, pe, po, two, sm, v, n);
    for (int k = 0; k < n; k++) begin
      tickBit(v[k], tag);
      if (k == 0) begin
        if (chkRdy) check("R3", "txRdy at first bit", txRdy, 1'b1);
        if (chkEmp) check("R10", "txEmpty on fill", txEmpty, 1'b1);
        if (wr2) begin
          writeByte(d2);
          check("R2", "txRdy after write", txRdy, 1'b0);
          check("R10", "txEmpty after write", txEmpty, 1'b0);
        end
      end
    end
  endtask

  task automatic t_reset();
    check("R1", "txd", txd, 1'b1);
    check("R1", "txRdy", txRdy, 1'b1);
    check("R1", "txEmpty", txEmpty, 1'b1);
  endtask

  task automatic t_async8();
    setCfg(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00);
    ctsN = 1'b0;
    writeByte(8'hA5);
    check("R2", "txRdy after write", txRdy, 1'b0);
    sendFrame(8'hA5, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R5", 1'b1, 1'b0, 1'b0, 8'h00);
    tickBit(1'b1, "R12");
    check("R12", "txEmpty after frame", txEmpty, 1'b1);
  endtask

  task automatic t_async5();
    setCfg(1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 8'h00);
    writeByte(8'hF3);
    sendFrame(8'hF3, 5, 1'b1, 1'b0, 1'b1, 1'b0, "R6", 1'b1, 1'b0, 1'b0, 8'h00);
    tickBit(1'b1, "R6");
  endtask

  task automatic t_async7odd();
    setCfg(1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00);
    writeByte(8'h55);
    sendFrame(8'h55, 7, 1'b1, 1'b1, 1'b0, 1'b0, "R7", 1'b1, 1'b0, 1'b0, 8'h00);
    tickBit(1'b1, "R7");
  endtask

  task automatic t_cts();
    setCfg(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00);
    ctsN = 1'b1;
    writeByte(8'h0F);
    for (int k = 0; k < 3; k++) begin
      tickBit(1'b1, "R4");
      check("R4", "byte still held", txRdy, 1'b0);
    end
    ctsN = 1'b0;
    sendFrame(8'h0F, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R4", 1'b1, 1'b0, 1'b0, 8'h00);
    tickBit(1'b1, "R12");
  endtask

  task automatic t_backToBack();
    writeByte(8'h3A);
    sendFrame(8'h3A, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R8", 1'b1, 1'b0, 1'b1, 8'hC5);
    sendFrame(8'hC5, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R8", 1'b1, 1'b0, 1'b0, 8'h00);
    tickBit(1'b1, "R8");
  endtask

  task automatic t_ignoreFull();
    ctsN = 1'b1;
    writeByte(8'h81);
    writeByte(8'h7E);
    check("R2", "txRdy while full", txRdy, 1'b0);
    ctsN = 1'b0;
    sendFrame(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R2", 1'b1, 1'b0, 1'b0, 8'h00);
    tickBit(1'b1, "R2");
    check("R2", "no second frame, txEmpty", txEmpty, 1'b1);
  endtask

  task automatic t_cfgFreeze();
    logic [7:0] oldBits;
    oldBits = 8'h0F;
    writeByte(8'h0F);
    tickBit(1'b0, "R11");
    setCfg(1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 8; i++) tickBit(oldBits[i], "R11");
    tickBit(1'b1, "R11");
    tickBit(1'b1, "R11");
    writeByte(8'h0E);
    sendFrame(8'h0E, 5, 1'b1, 1'b0, 1'b1, 1'b0, "R11", 1'b1, 1'b0, 1'b0, 8'h00);
    tickBit(1'b1, "R11");
    setCfg(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_sync();
    ctsN = 1'b1;
    setCfg(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h97);
    writeByte(8'h3C);
    ctsN = 1'b0;
    sendFrame(8'h97, 8, 1'b0, 1'b0, 1'b0, 1'b1, "R9", 1'b0, 1'b0, 1'b0, 8'h00);
    sendFrame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b1, "R9", 1'b1, 1'b0, 1'b0, 8'h00);
    sendFrame(8'h97, 8, 1'b0, 1'b0, 1'b0, 1'b1, "R10", 1'b0, 1'b1, 1'b1, 8'hC3);
    sendFrame(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b1, "R10", 1'b1, 1'b0, 1'b0, 8'h00);
    ctsN = 1'b1;
    tickBit(1'b1, "R4");
    tickBit(1'b1, "R12");
    ctsN = 1'b0;
    setCfg(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_async8();
    t_async5();
    t_async7odd();
    t_cts();
    t_backToBack();
    t_ignoreFull();
    t_cfgFreeze();
    t_sync();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule